// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt requests from up to sixteen peripherals and presents one pending line to the CPU. Each request input is a one-cycle pulse. The pulse sets a sticky bit in a status register, and that bit holds until software acknowledges it. A second register holds an enable mask. The pending output is high whenever some status bit is set and its mask bit is also set.

Software reaches both registers over a simple word-addressed register bus. The status register sits at byte offset 0x0 and the mask register at offset 0x4. Writing to the status register ANDs the old contents with the written value. A zero bit therefore acknowledges its request, and a one bit leaves it unchanged. Writing to the mask register replaces the whole mask.

The pending line is combinational from the two registers, so it follows every register update in the same cycle that the update takes effect. Source 3 is wired by convention to the DMA controller. The block treats it like any other source.

The bus decoder classifies each access as one of three kinds: `SEL_STAT` for offset 0x0, `SEL_MASK` for offset 0x4, and `SEL_NONE` for any other offset. No other sequencing exists.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: While reset is asserted and right after it, status and mask both read zero and `irq_pending` is low.
- R2: A high bit on `src_req` sets the matching status bit at the next clock edge. The bit stays set through later cycles until it is acknowledged.
- R3: A write to offset 0x0 makes the new status equal to the old status AND `bus_wdata[15:0]`. A zero bit clears its status bit and a one bit keeps it.
- R4: When a request pulse and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x4 replaces the mask with `bus_wdata[15:0]`. Bits 31:16 of the written word have no effect.
- R6: After each clock edge, `irq_pending` equals the OR over all bits of status AND mask, including right after any status or mask write.
- R7: A mask write that enables an already-set status bit raises `irq_pending` directly after that write's clock edge.
- R8: With `bus_rd` high, `bus_rdata` returns the status (offset 0x0) or the mask (offset 0x4), zero-extended, in the same cycle. A read changes no register.
- R9: A write to any offset other than 0x0 or 0x4 changes no register. A read of such an offset, or any cycle with `bus_rd` low, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 16 | One-cycle request pulses, one per source (bit 3: DMA controller) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Read data, combinational |
| irq_pending | output | 1 | High when any enabled status bit is set |

## Verification
The bench targets these corner cases:
- A request pulse arriving in the same cycle as a zero acknowledge. A design where the acknowledge wins would lose the interrupt.
- Acknowledge data containing ones. A design that overwrites the status instead of ANDing it would set bits that never fired, or clear bits that were not acknowledged.
- Unmasking a bit that is already pending. A design that updates the pending line only on a new request would leave the CPU waiting.
- Upper data bits on mask writes, writes to unused offsets, and repeated reads. Each of these would corrupt a register if decoded loosely.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int unsigned ADDR_W   = 12;
    localparam logic [ADDR_W-1:0] OFF_STAT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_MASK = 12'h004;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/isc_decode.sv
module isc_decode
    import isc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            OFF_STAT: sel = SEL_STAT;
            OFF_MASK: sel = SEL_MASK;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/isc_status_bank.sv
module isc_status_bank #(
    parameter int unsigned SRC_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] req,
    input  logic             ack_we,
    input  logic [SRC_N-1:0] ack_val,
    output logic [SRC_N-1:0] stat_q
);
    logic [SRC_N-1:0] keep;

    // Per-bit keep term: a zero in the written word drops the bit.
    always_comb keep = ack_we ? ack_val : '1;

    // A new request is ORed in after the acknowledge, so the set wins.
    genvar gi;
    generate
        for (gi = 0; gi < SRC_N; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stat_q[gi] <= 1'b0;
                else        stat_q[gi] <= (stat_q[gi] & keep[gi]) | req[gi];
            end
        end
    endgenerate
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
    parameter int unsigned SRC_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SRC_N-1:0] val,
    output logic [SRC_N-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mask_q <= '0;
        else if (we) mask_q <= val;
    end
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl
    import isc_pkg::*;
#(
    parameter int unsigned SRC_N  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_req,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pending
);
    reg_sel_e         sel;
    logic             wr_stat;
    logic             wr_mask;
    logic [SRC_N-1:0] stat_q;
    logic [SRC_N-1:0] mask_q;
    logic             unused_wdata;

    // Bits above SRC_N of the write word are dropped on purpose.
    assign unused_wdata = ^bus_wdata;

    isc_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_stat = bus_wr && (sel == SEL_STAT);
    assign wr_mask = bus_wr && (sel == SEL_MASK);

    isc_status_bank #(.SRC_N(SRC_N)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (src_req),
        .ack_we  (wr_stat),
        .ack_val (bus_wdata[SRC_N-1:0]),
        .stat_q  (stat_q)
    );

    isc_mask_reg #(.SRC_N(SRC_N)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_mask),
        .val    (bus_wdata[SRC_N-1:0]),
        .mask_q (mask_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_STAT: bus_rdata[SRC_N-1:0] = stat_q;
                SEL_MASK: bus_rdata[SRC_N-1:0] = mask_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_pending = |(stat_q & mask_q);
endmodule

// File: rtl/isc_checker.sv
module isc_checker
    import isc_pkg::*;
#(
    parameter int unsigned SRC_N  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_N-1:0]  src_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [SRC_N-1:0]  stat_q,
    input logic [SRC_N-1:0]  mask_q,
    input logic              irq_pending
);
    logic w_stat, w_mask;
    assign w_stat = bus_wr && (bus_addr == OFF_STAT);
    assign w_mask = bus_wr && (bus_addr == OFF_MASK);

    // R2: requested bits are present after the edge
    a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_req) |=> ((stat_q & $past(src_req)) == $past(src_req)));

    // R2: with no request and no status write the status holds
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|src_req) && !w_stat) |=> $stable(stat_q));

    // R3 and R4: acknowledge ANDs, request wins
    a_r3_ack_and: assert property (@(posedge clk) disable iff (!rst_n)
        w_stat |=> (stat_q == (($past(stat_q) & $past(bus_wdata[SRC_N-1:0])) | $past(src_req))));

    // R5: mask write replaces
    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        w_mask |=> (mask_q == $past(bus_wdata[SRC_N-1:0])));

    // R9: mask moves only on its own write
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !w_mask |=> $stable(mask_q));

    // R6 and R7: pending rises only after a request or mask write
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> ($past(|src_req) || $past(w_mask)));

    // R6: pending falls only after a register write
    a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pending) |-> ($past(w_stat) || $past(w_mask)));
endmodule

bind irq_stat_mask_ctrl isc_checker #(.SRC_N(SRC_N), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req     (src_req),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .stat_q      (stat_q),
    .mask_q      (mask_q),
    .irq_pending (irq_pending)
);

// File: tb/irq_stat_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_stat_mask_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_req = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pending;

    int total = 0;
    int bad = 0;
    logic [15:0] m_stat = '0;
    logic [15:0] m_mask = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_stat_mask_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pending(irq_pending)
    );

    function automatic logic [15:0] next_stat(logic [15:0] s, logic [15:0] r,
                                              logic we, logic [15:0] d);
        return (s & (we ? d : 16'hFFFF)) | r;
    endfunction

    function automatic logic exp_pend(logic [15:0] s, logic [15:0] m);
        return |(s & m);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle plus request pulses; model updated at the edge.
    task automatic cyc(logic [15:0] req, logic wr, logic rd,
                       logic [11:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        src_req = req; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        if (rd) begin
            if (a == 12'h000)      check({tag, " R8 stat read"}, bus_rdata, {16'h0, m_stat});
            else if (a == 12'h004) check({tag, " R8 mask read"}, bus_rdata, {16'h0, m_mask});
            else                   check({tag, " R9 unmapped read"}, bus_rdata, 32'h0);
        end else begin
            check({tag, " R9 idle rdata"}, bus_rdata, 32'h0);
        end
        @(posedge clk);
        m_stat = next_stat(m_stat, req, wr && a == 12'h000, d[15:0]);
        if (wr && a == 12'h004) m_mask = d[15:0];
        #1;
        check({tag, " R6 pending"}, {31'h0, irq_pending}, {31'h0, exp_pend(m_stat, m_mask)});
    endtask

    task automatic rd_stat(string tag); cyc('0, 0, 1, 12'h000, '0, tag); endtask
    task automatic rd_mask(string tag); cyc('0, 0, 1, 12'h004, '0, tag); endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        #1;
        check("R1 pending in reset", {31'h0, irq_pending}, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        rd_stat("R1 reset");
        rd_mask("R1 reset");

        // R2: sticky set, masked so no pending
        cyc(16'h0008, 0, 0, 0, 0, "R2 dma req");
        cyc('0, 0, 0, 0, 0, "R2 hold");
        rd_stat("R2 sticky");
        // R7: unmask an already-set bit
        cyc('0, 1, 0, 12'h004, 32'h0000_0008, "R7 unmask");
        check("R7 pending high", {31'h0, irq_pending}, 32'h1);
        // R3: ones keep, zero clears
        cyc(16'h0100, 0, 0, 0, 0, "R3 prep");
        cyc('0, 1, 0, 12'h000, 32'h0000_FEFF, "R3 ack bit8");
        rd_stat("R3 after ack");
        cyc('0, 1, 0, 12'h000, 32'hFFFF_FFF7, "R3 ack bit3");
        check("R3 pending low", {31'h0, irq_pending}, 32'h0);
        // R4: set wins over same-cycle acknowledge
        cyc(16'h0020, 1, 0, 12'h000, 32'h0, "R4 race");
        rd_stat("R4 after race");
        check("R4 stat bit5", {16'h0, m_stat}, 32'h0000_0020);
        // R5: upper bits ignored
        cyc('0, 1, 0, 12'h004, 32'hFFFF_0020, "R5 mask hi");
        rd_mask("R5 after write");
        check("R5 pending", {31'h0, irq_pending}, 32'h1);
        // R9: unmapped write changes nothing
        cyc('0, 1, 0, 12'h008, 32'h0000_0000, "R9 wr 0x8");
        rd_stat("R9 stat kept");
        rd_mask("R9 mask kept");
        cyc('0, 0, 1, 12'h00C, 0, "R9 rd 0xC");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] rq;
            int op;
            rq = (($urandom % 4) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
            op = $urandom % 7;
            case (op)
                0: cyc(rq, 1, 0, 12'h000, $urandom | $urandom, "R3 rnd ack");
                1: cyc(rq, 1, 0, 12'h004, $urandom, "R5 rnd mask");
                2: cyc(rq, 0, 1, 12'h000, 0, "R8 rnd");
                3: cyc(rq, 0, 1, 12'h004, 0, "R8 rnd");
                4: cyc(rq, 1, 1, 12'h000 + 12'(4 * (2 + $urandom % 4)), $urandom, "R9 rnd");
                default: cyc(rq, 0, 0, 0, 0, "R2 rnd");
            endcase
        end
        rd_stat("R8 final");
        rd_mask("R8 final");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule